// File: doc/BRIEF.md
# Lane Marker Detector

This block sits on one received lane of a four-lane link. The lane arrives as a stream of 10-bit symbols that are already word-aligned, one symbol on each cycle with the valid flag high. The block looks for the periodic alignment-marker field in that stream and works out which logical lane the physical lane carries. It does this by reading the lane-specific marker symbols. It then gives a later deskew stage a timing reference: a one-cycle pulse on the last symbol of each accepted marker field.

Each marker field occupies 12 symbols on a lane. The first five symbols are enough to classify it. Symbols 1, 2 and 5 carry the same value on every lane. Symbol 3 differs between lanes, and symbol 4 separates lanes 0 and 1 but gives the same value on lanes 2 and 3. A field is only trusted after it repeats at the expected spacing. Lock is held through isolated corrupted fields and is released after a run of missed fields.

Top module: `am_lane_detect`

## Requirements
- R1: While rst_ni is low, and after it is released until the first accepted symbol, lock_o, am_end_o and id_err_o are 0 and lane_id_o is 0.
- R2: A marker candidate is five consecutive accepted symbols S1..S5 with S1=0101100101, S2=0100100110 and S5=1010110110, where the pair (S3,S4) equals one lane's pair. The lane pairs are: lane 0 (0100011011, 0110100110), lane 1 (0100001000, 0010100110), lane 2 (0100011000, 1010100110) and lane 3 (0100010110, 1010100110). The matching lane number k, in 2-bit binary, is the identity. lane_id_o shows the identity captured by the most recent candidate that started a search, from the cycle after the edge that accepts its S5.
- R3: lock_o rises in the cycle after the edge that accepts S5 of the second of two candidates with the same identity whose S5 symbols are exactly AM_SPACING accepted symbols apart.
- R4: Before lock, if the accepted symbol at the expected S5 position does not complete a candidate of the captured identity, the search ends. This covers a wrong spacing and a different identity. The symbol at that position starts no new search, and a later candidate starts a fresh one.
- R5: When S1, S2 and S5 match but (S3,S4) matches no single lane's pair, id_err_o pulses for one cycle after the edge that accepts S5. Such a field neither starts a search nor confirms or keeps lock, and it leaves lane_id_o unchanged.
- R6: While locked, one expected S5 position is checked every AM_SPACING accepted symbols. A hit resets the miss count. Three consecutive misses clear lock_o after the edge accepting the third missed S5; one or two misses followed by a hit keep lock.
- R7: am_end_o pulses for one cycle after the edge that accepts S12 of every field whose expected S5 hit while locked, including the field that produced lock. There is no pulse for a missed field.
- R8: Cycles with sym_valid_i low are ignored. Their symbol value has no effect, and they advance neither the symbol history nor the spacing count.
- R9: While locked, lane_id_o does not change, and candidates at positions other than the expected S5 position are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | sym_i carries a symbol this cycle |
| sym_i | input | 10 | Received word-aligned symbol, first-sent bit in bit 9 |
| lock_o | output | 1 | Lane identity confirmed and tracked |
| lane_id_o | output | 2 | Logical lane number carried by this physical lane |
| am_end_o | output | 1 | One-cycle pulse after the last symbol of an accepted marker field |
| id_err_o | output | 1 | One-cycle pulse for a field with valid common symbols but no lane match |

## Verification
On every cycle, the assertions check the following: at most one lane pair matches, and lock only rises on an accepted symbol. While locked, the identity holds steady and end pulses occur only under lock and never back to back. Idle cycles raise neither pulse, and an error pulse never coincides with lock rising. The exact timing of lock rise and release against the marker spacing, and the count of end pulses per field, can only be shown by the bench's scenarios. The same holds for rejecting mis-spaced and mixed-lane fields and for ignoring out-of-place markers; the bench's reference model follows these cycle by cycle.

// File: rtl/am_det_pkg.sv
package am_det_pkg;
  localparam int SYM_W     = 10;
  localparam int NUM_LANES = 4;
  localparam int LANE_W    = $clog2(NUM_LANES);
  localparam int MARK_LEN  = 12;
  localparam int MATCH_LEN = 5;
  localparam int HIST_LEN  = MATCH_LEN - 1;
  // accepted symbols after S5 at which S12 arrives, minus one
  localparam int END_OFS   = MARK_LEN - MATCH_LEN - 1;

  localparam logic [SYM_W-1:0] SYM_HEAD0 = 10'b0101100101;
  localparam logic [SYM_W-1:0] SYM_HEAD1 = 10'b0100100110;
  localparam logic [SYM_W-1:0] SYM_TAIL  = 10'b1010110110;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } det_state_e;

  function automatic logic [SYM_W-1:0] lane_tag_sym(input int unsigned k);
    case (k)
      0:       return 10'b0100011011;
      1:       return 10'b0100001000;
      2:       return 10'b0100011000;
      default: return 10'b0100010110;
    endcase
  endfunction

  function automatic logic [SYM_W-1:0] lane_sub_sym(input int unsigned k);
    case (k)
      0:       return 10'b0110100110;
      1:       return 10'b0010100110;
      default: return 10'b1010100110;
    endcase
  endfunction
endpackage

// File: rtl/am_sym_hist.sv
module am_sym_hist
  import am_det_pkg::*;
#(
  parameter int DEPTH = HIST_LEN
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [SYM_W-1:0]            sym_i,
  output logic [DEPTH-1:0][SYM_W-1:0] hist_o
);
  logic [DEPTH-1:0][SYM_W-1:0] hist_q;

  // hist_q[0] is the newest accepted symbol
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_q[i] <= '0;
      end else if (valid_i) begin
        if (i == 0) hist_q[i] <= sym_i;
        else        hist_q[i] <= hist_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/am_field_match.sv
module am_field_match
  import am_det_pkg::*;
(
  input  logic                           valid_i,
  input  logic [HIST_LEN-1:0][SYM_W-1:0] hist_i,
  input  logic [SYM_W-1:0]               sym_i,
  output logic [NUM_LANES-1:0]           hit_o,
  output logic                           lane_hit_o,
  output logic [LANE_W-1:0]              lane_o,
  output logic                           id_err_o
);
  // window: hist_i[3]=S1, [2]=S2, [1]=S3, [0]=S4, sym_i=S5
  logic common;
  assign common = valid_i
                & (hist_i[3] == SYM_HEAD0)
                & (hist_i[2] == SYM_HEAD1)
                & (sym_i     == SYM_TAIL);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam logic [SYM_W-1:0] TAG = lane_tag_sym(k);
    localparam logic [SYM_W-1:0] SUB = lane_sub_sym(k);
    assign hit_o[k] = common & (hist_i[1] == TAG) & (hist_i[0] == SUB);
  end

  always_comb begin
    lane_o = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (hit_o[k]) lane_o = LANE_W'(k);
    end
  end

  assign lane_hit_o = |hit_o;
  assign id_err_o   = common & ~lane_hit_o;
endmodule

// File: rtl/am_lock_fsm.sv
module am_lock_fsm
  import am_det_pkg::*;
#(
  parameter int AM_SPACING  = 16384,
  parameter int LOCK_FIELDS = 2,
  parameter int MISS_LIMIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              lane_hit_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              id_err_i,
  output logic              lock_o,
  output logic [LANE_W-1:0] lane_id_o,
  output logic              am_end_o,
  output logic              id_err_o
);
  localparam int POS_W  = $clog2(AM_SPACING);
  localparam int CONF_W = $clog2(LOCK_FIELDS + 1);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  det_state_e        st_q;
  logic [POS_W-1:0]  pos_q;
  logic [CONF_W-1:0] conf_q;
  logic [MISS_W-1:0] miss_q;
  logic [LANE_W-1:0] id_q;
  logic              anchor_q;
  logic              end_q;
  logic              err_q;
  logic              at_slot;
  logic              same_id;

  assign at_slot = (pos_q == POS_W'(AM_SPACING - 1));
  assign same_id = lane_hit_i & (lane_i == id_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_HUNT;
      pos_q    <= '0;
      conf_q   <= '0;
      miss_q   <= '0;
      id_q     <= '0;
      anchor_q <= 1'b0;
      end_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      end_q <= 1'b0;
      err_q <= 1'b0;
      if (valid_i) begin
        err_q <= id_err_i;
        unique case (st_q)
          ST_HUNT: begin
            if (lane_hit_i) begin
              st_q   <= ST_VERIFY;
              id_q   <= lane_i;
              pos_q  <= '0;
              conf_q <= CONF_W'(1);
            end
          end
          ST_VERIFY: begin
            if (at_slot) begin
              pos_q <= '0;
              if (same_id) begin
                conf_q <= conf_q + CONF_W'(1);
                if (conf_q == CONF_W'(LOCK_FIELDS - 1)) begin
                  st_q     <= ST_LOCKED;
                  anchor_q <= 1'b1;
                  miss_q   <= '0;
                end
              end else begin
                st_q <= ST_HUNT;
              end
            end else begin
              pos_q <= pos_q + POS_W'(1);
            end
          end
          ST_LOCKED: begin
            if (at_slot) begin
              pos_q <= '0;
              if (same_id) begin
                miss_q   <= '0;
                anchor_q <= 1'b1;
              end else begin
                anchor_q <= 1'b0;
                if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                  st_q   <= ST_HUNT;
                  miss_q <= '0;
                end else begin
                  miss_q <= miss_q + MISS_W'(1);
                end
              end
            end else begin
              pos_q <= pos_q + POS_W'(1);
              if (anchor_q && pos_q == POS_W'(END_OFS)) end_q <= 1'b1;
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign lock_o    = (st_q == ST_LOCKED);
  assign lane_id_o = id_q;
  assign am_end_o  = end_q;
  assign id_err_o  = err_q;
endmodule

// File: rtl/am_lane_detect.sv
module am_lane_detect
  import am_det_pkg::*;
#(
  parameter int AM_SPACING  = 16384,
  parameter int LOCK_FIELDS = 2,
  parameter int MISS_LIMIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_valid_i,
  input  logic [SYM_W-1:0]  sym_i,
  output logic              lock_o,
  output logic [LANE_W-1:0] lane_id_o,
  output logic              am_end_o,
  output logic              id_err_o
);
  logic [HIST_LEN-1:0][SYM_W-1:0] hist;
  logic [NUM_LANES-1:0]           lane_hits;
  logic                           lane_hit;
  logic [LANE_W-1:0]              lane_num;
  logic                           mix_err;

  am_sym_hist #(.DEPTH(HIST_LEN)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sym_valid_i),
    .sym_i   (sym_i),
    .hist_o  (hist)
  );

  am_field_match u_match (
    .valid_i    (sym_valid_i),
    .hist_i     (hist),
    .sym_i      (sym_i),
    .hit_o      (lane_hits),
    .lane_hit_o (lane_hit),
    .lane_o     (lane_num),
    .id_err_o   (mix_err)
  );

  am_lock_fsm #(
    .AM_SPACING  (AM_SPACING),
    .LOCK_FIELDS (LOCK_FIELDS),
    .MISS_LIMIT  (MISS_LIMIT)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sym_valid_i),
    .lane_hit_i (lane_hit),
    .lane_i     (lane_num),
    .id_err_i   (mix_err),
    .lock_o     (lock_o),
    .lane_id_o  (lane_id_o),
    .am_end_o   (am_end_o),
    .id_err_o   (id_err_o)
  );
endmodule

// File: rtl/am_lane_detect_chk.sv
module am_lane_detect_chk
  import am_det_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sym_valid_i,
  input logic                 lock_o,
  input logic [LANE_W-1:0]    lane_id_o,
  input logic                 am_end_o,
  input logic                 id_err_o,
  input logic [NUM_LANES-1:0] lane_hits
);
  a_r2_hit_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_hits));

  a_r3_lock_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(sym_valid_i));

  a_r9_id_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |-> $stable(lane_id_o));

  a_r7_end_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    am_end_o |-> lock_o);

  a_r7_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    am_end_o |=> !am_end_o);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sym_valid_i) |-> (!am_end_o && !id_err_o));

  a_r5_err_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_err_o |-> !$rose(lock_o));
endmodule

bind am_lane_detect am_lane_detect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .lock_o      (lock_o),
  .lane_id_o   (lane_id_o),
  .am_end_o    (am_end_o),
  .id_err_o    (id_err_o),
  .lane_hits   (lane_hits)
);

// File: tb/am_lane_detect_test.sv
`timescale 1ns/1ps
module am_lane_detect_test;
  localparam int SP   = 40;
  localparam int MISS = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vld = 1'b0;
  logic [9:0] sym = '0;
  logic       lock_o, am_end_o, id_err_o;
  logic [1:0] lane_id_o;

  always #2.5 clk = ~clk;

  am_lane_detect #(.AM_SPACING(SP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sym_valid_i(vld), .sym_i(sym),
    .lock_o(lock_o), .lane_id_o(lane_id_o), .am_end_o(am_end_o), .id_err_o(id_err_o)
  );

  localparam logic [9:0] H0 = 10'b0101100101;
  localparam logic [9:0] H1 = 10'b0100100110;
  localparam logic [9:0] T5 = 10'b1010110110;
  logic [9:0] tag [4];
  logic [9:0] sub [4];
  initial begin
    tag[0] = 10'b0100011011; tag[1] = 10'b0100001000;
    tag[2] = 10'b0100011000; tag[3] = 10'b0100010110;
    sub[0] = 10'b0110100110; sub[1] = 10'b0010100110;
    sub[2] = 10'b1010100110; sub[3] = 10'b1010100110;
  end

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  task automatic chk(string tag_s, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag_s, act, exp);
    end
  endtask

  // reference model: 0 hunt, 1 verify, 2 locked
  logic [9:0] win[$];
  int m_st = 0, m_pos = 0, m_conf = 0, m_miss = 0, m_id = 0;
  bit m_anchor = 0, m_end = 0, m_err = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_ni) begin
      win.delete();
      m_st = 0; m_pos = 0; m_conf = 0; m_miss = 0; m_id = 0;
      m_anchor = 0; m_end = 0; m_err = 0;
    end else begin
      m_end = 0; m_err = 0;
      if (vld) begin
        int lane;
        bit common;
        win.push_back(sym);
        if (win.size() > 5) void'(win.pop_front());
        common = (win.size() == 5) && win[0] == H0 && win[1] == H1 && win[4] == T5;
        lane = -1;
        if (common)
          for (int k = 0; k < 4; k++)
            if (win[2] == tag[k] && win[3] == sub[k]) lane = k;
        if (common && lane < 0) m_err = 1;
        if (m_st == 0) begin
          if (lane >= 0) begin m_st = 1; m_id = lane; m_pos = 0; m_conf = 1; end
        end else if (m_pos == SP - 1) begin
          m_pos = 0;
          if (m_st == 1) begin
            if (lane == m_id) begin
              m_conf++;
              if (m_conf >= 2) begin m_st = 2; m_anchor = 1; m_miss = 0; end
            end else m_st = 0;
          end else begin
            if (lane == m_id) begin m_miss = 0; m_anchor = 1; end
            else begin
              m_anchor = 0; m_miss++;
              if (m_miss == MISS) begin m_st = 0; m_miss = 0; end
            end
          end
        end else begin
          if (m_st == 2 && m_anchor && m_pos == 6) m_end = 1;
          m_pos++;
        end
      end
    end
  end

  int n_end = 0, n_err = 0;
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 lock vs model", int'(lock_o), (m_st == 2) ? 1 : 0);
      chk("R2 lane id vs model", int'(lane_id_o), m_id);
      chk("R7 marker end vs model", int'(am_end_o), int'(m_end));
      chk("R5 id error vs model", int'(id_err_o), int'(m_err));
    end
    if (am_end_o) n_end++;
    if (id_err_o) n_err++;
  end

  task automatic put(input logic [9:0] s, input bit v);
    @(negedge clk);
    sym = s;
    vld = v;
  endtask

  // kind: 0 good, 1 corrupted head, 2 mixed lane pair
  task automatic field(input int lane, input int kind, input int len,
                       input int gap, input int inj);
    logic [9:0] m [12];
    m[0] = (kind == 1) ? ~H0 : H0;
    m[1] = H1;
    m[2] = (kind == 2) ? tag[0] : tag[lane];
    m[3] = (kind == 2) ? sub[1] : sub[lane];
    m[4] = T5;
    for (int i = 5; i < 12; i++) m[i] = 10'h2A0 + 10'(i);
    for (int i = 0; i < len; i++) begin
      logic [9:0] s;
      s = (i < 12) ? m[i] : 10'((i * 53 + 7) & 10'h1ff);
      if (inj >= 0 && i >= 20 && i < 25) begin
        case (i - 20)
          0: s = H0;
          1: s = H1;
          2: s = tag[inj];
          3: s = sub[inj];
          default: s = T5;
        endcase
      end
      put(s, 1'b1);
      if (gap > 0 && (i % gap) == 0) put(H0, 1'b0);
    end
  endtask

  task automatic idle2();
    put(T5, 1'b0);
    put(T5, 1'b0);
  endtask

  initial begin
    int b_end, b_err;
    repeat (3) @(negedge clk);
    chk("R1 reset lock", int'(lock_o), 0);
    chk("R1 reset lane id", int'(lane_id_o), 0);
    chk("R1 reset end", int'(am_end_o), 0);
    chk("R1 reset err", int'(id_err_o), 0);
    rst_ni = 1'b1;
    idle2();
    chk("R1 idle after reset", int'(lock_o), 0);

    // R2 R3 R7: lane 2 locks on second field
    b_end = n_end;
    field(2, 0, SP, 0, -1);
    chk("R3 no lock after one field", int'(lock_o), 0);
    field(2, 0, SP, 0, -1);
    field(2, 0, SP, 0, -1);
    idle2();
    chk("R3 locked", int'(lock_o), 1);
    chk("R2 lane 2", int'(lane_id_o), 2);
    chk("R7 end pulses", n_end - b_end, 2);

    // R8: idle cycles inside fields
    b_end = n_end;
    field(2, 0, SP, 3, -1);
    field(2, 0, SP, 3, -1);
    idle2();
    chk("R8 lock held with gaps", int'(lock_o), 1);
    chk("R8 end pulses with gaps", n_end - b_end, 2);

    // R9: misplaced lane 1 marker ignored
    b_end = n_end;
    field(2, 0, SP, 0, 1);
    field(2, 0, SP, 0, -1);
    idle2();
    chk("R9 id kept", int'(lane_id_o), 2);
    chk("R9 lock kept", int'(lock_o), 1);
    chk("R9 end pulses", n_end - b_end, 2);

    // R6: two misses then hit keep lock
    b_end = n_end;
    field(2, 1, SP, 0, -1);
    field(2, 1, SP, 0, -1);
    chk("R6 lock after two misses", int'(lock_o), 1);
    field(2, 0, SP, 0, -1);
    idle2();
    chk("R6 lock kept", int'(lock_o), 1);
    chk("R7 no end on missed fields", n_end - b_end, 1);

    // R6: three misses drop lock
    field(2, 1, SP, 0, -1);
    field(2, 1, SP, 0, -1);
    field(2, 1, SP, 0, -1);
    idle2();
    chk("R6 lock dropped", int'(lock_o), 0);

    // R5: mixed lane pair
    b_err = n_err;
    field(0, 2, SP, 0, -1);
    field(0, 2, SP, 0, -1);
    idle2();
    chk("R5 error pulses", n_err - b_err, 2);
    chk("R5 no lock", int'(lock_o), 0);
    chk("R5 id unchanged", int'(lane_id_o), 2);

    // R4: wrong spacing, then other lane at slot
    field(3, 0, SP + 1, 0, -1);
    field(3, 0, SP, 0, -1);
    idle2();
    chk("R4 no lock on bad spacing", int'(lock_o), 0);
    chk("R2 lane 3 captured", int'(lane_id_o), 3);
    field(0, 0, SP, 0, -1);
    field(0, 0, SP, 0, -1);
    idle2();
    chk("R4 no lock on lane change", int'(lock_o), 0);
    field(0, 0, SP, 0, -1);
    idle2();
    chk("R4 lock after fresh search", int'(lock_o), 1);
    chk("R2 lane 0", int'(lane_id_o), 0);

    // R2: lanes 1 and 3
    for (int ln = 1; ln < 4; ln += 2) begin
      for (int j = 0; j < 3; j++) field(0, 1, SP, 0, -1);
      field(ln, 0, SP, 0, -1);
      field(ln, 0, SP, 0, -1);
      idle2();
      chk("R2 lock other lane", int'(lock_o), 1);
      chk("R2 lane id other lane", int'(lane_id_o), ln);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule